// File: doc/BRIEF.md
# Two-Channel DMA Controller

This block is a small DMA engine with two channels that share one bus-master port. Each channel copies a programmed number of elements from a source address to a destination address. An element is 8, 16 or 32 bits wide. The source and destination pointers each either step by the element size or stay fixed. A transfer is started in one of two ways: software sets a request bit, or a hardware requester raises one of several request lines and the channel selects which line it listens to. Several requesters can therefore be routed to one channel.

An arbiter picks between the two channels, either by fixed priority or by rotating priority. A channel runs in one of two modes:
- Cycle-steal: one element per request, after which the bus is handed back.
- Burst: a single request moves the whole count back to back.

When a channel's count runs out, it sets a sticky done flag, drops its enable, and can raise the interrupt.

The bus port is a plain request/ready handshake. While `bus_ready` is low, the engine holds the access steady. Each element is one read of the source followed by one write of the destination.

Top module: `dual_dma`

## Requirements
- R1: After reset, `bus_req`, `irq` and `hw_ack` are low, and every register reads 0.
- R2: Register map, word index on `reg_addr`: channel c uses index 4c+0 for the source pointer, 4c+1 for the destination pointer, 4c+2 for the count (bits 15:0) and 4c+3 for control. Index 8 bit 0 selects the arbitration mode (0 fixed, 1 rotating). The pointers and the count read back what was written.
- R3: Control register fields:
  - bit 0 enables the channel;
  - bit 1 is the software request; writing 1 together with bit 0 makes a request pending, and it reads back as 1 until the request is served;
  - bit 2 selects burst (1) or cycle-steal (0);
  - bits 4:3 give the size (0 = 8-bit, 1 = 16-bit, 2 = 32-bit);
  - bit 5 selects source increment and bit 6 destination increment;
  - bit 7 enables the interrupt;
  - bit 8 selects hardware request mode;
  - bits 10:9 select the hardware request line;
  - bit 16 reads the done flag, and writing 1 to it clears the flag.
- R4: In cycle-steal mode, each request moves exactly one element. `bus_req` then goes low for at least one cycle, and the count drops by one.
- R5: In burst mode, one request moves the whole count with `bus_req` held high from the first read to the last write.
- R6: In hardware mode, a channel requests while its selected `hw_req` line is high. `hw_ack` pulses on that line only, during the cycle in which the request's last write is accepted. That is every element in cycle-steal mode, and the final element in burst mode.
- R7: `bus_size` carries the size code. Only the low 8, 16 or 32 bits of `bus_rdata` are used, and the element is written with the same size.
- R8: An incrementing pointer advances by 1, 2 or 4 bytes per element according to the size. A fixed pointer keeps its value.
- R9: A count of 0 means 65,536 elements: after three single transfers it reads 0xFFFD and the channel is not done.
- R10: After the last element, the done flag is set and the enable bit clears. `irq` is high while any channel has done and interrupt enable both set.
- R11: In fixed mode, channel 0 is served before channel 1 whenever both request.
- R12: In rotating mode, when both channels keep requesting, the grants alternate between them.
- R13: While `bus_req` is high and `bus_ready` is low, the engine keeps `bus_req`, `bus_we` and `bus_addr` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_req | input | 4 | Hardware request lines |
| hw_ack | output | 4 | Hardware acknowledge, one per line |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 2 | Access size code |
| bus_wdata | output | 32 | Write data, right-aligned |
| bus_rdata | input | 32 | Read data, right-aligned |
| bus_ready | input | 1 | Access accepted this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong pointer or count inside a channel shows up as corrupted destination memory when its run ends. A count that is wrong by one appears after a single cycle-steal request, as a count readback off by one or a done flag that is set early. A broken arbiter shows up as the wrong channel's source address on the very first read after both channels request. A broken engine sequencer shows up within the same element: an extra `bus_req` release in burst mode, a missing release in cycle-steal mode, or `hw_ack` on a line that was not selected.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int CNT_W  = 16;
    localparam int NSRC   = 4;
    localparam int SEL_W  = $clog2(NSRC);
    localparam int NCH    = 2;
    localparam int CH_W   = 1;
    localparam int REG_AW = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} eng_st_e;

    typedef struct packed {
        logic             en;
        logic             pend;
        logic             burst;
        logic [1:0]       size;
        logic             src_inc;
        logic             dst_inc;
        logic             irq_en;
        logic             hw_mode;
        logic [SEL_W-1:0] sel;
    } chan_cfg_t;

    // Byte step for one element of the given size code.
    function automatic logic [2:0] size_step(input logic [1:0] sz);
        case (sz)
            2'd0:    size_step = 3'd1;
            2'd1:    size_step = 3'd2;
            default: size_step = 3'd4;
        endcase
    endfunction

    function automatic logic [DW-1:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    size_mask = DW'(32'h0000_00FF);
            2'd1:    size_mask = DW'(32'h0000_FFFF);
            default: size_mask = DW'(32'hFFFF_FFFF);
        endcase
    endfunction

    function automatic logic [31:0] pack_ctrl(input chan_cfg_t c, input logic done);
        logic [31:0] w;
        w = '0;
        w[0]          = c.en;
        w[1]          = c.pend;
        w[2]          = c.burst;
        w[4:3]        = c.size;
        w[5]          = c.src_inc;
        w[6]          = c.dst_inc;
        w[7]          = c.irq_en;
        w[8]          = c.hw_mode;
        w[9 +: SEL_W] = c.sel;
        w[16]         = done;
        return w;
    endfunction
endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           wr_field,
    input  logic [31:0]          wr_data,
    input  logic [1:0]           rd_field,
    output logic [31:0]          rd_data,
    input  logic [NSRC-1:0]      hw_req,
    input  logic                 adv,
    input  logic                 svc,
    output logic                 req_o,
    output logic                 last_o,
    output logic [AW-1:0]        src_o,
    output logic [AW-1:0]        dst_o,
    output logic                 burst_o,
    output logic [1:0]           size_o,
    output logic                 hw_mode_o,
    output logic [SEL_W-1:0]     sel_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] cnt;
        chan_cfg_t        cfg;
        logic             done;
    } chan_st_t;

    chan_st_t q, d;
    logic [AW-1:0] step;
    logic unused_wbits;

    assign unused_wbits = ^wr_data[31:17];
    assign step = AW'(size_step(q.cfg.size));

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_field)
                2'd0: d.src = wr_data[AW-1:0];
                2'd1: d.dst = wr_data[AW-1:0];
                2'd2: d.cnt = wr_data[CNT_W-1:0];
                default: begin
                    d.cfg.en      = wr_data[0];
                    d.cfg.pend    = wr_data[0] & wr_data[1];
                    d.cfg.burst   = wr_data[2];
                    d.cfg.size    = wr_data[4:3];
                    d.cfg.src_inc = wr_data[5];
                    d.cfg.dst_inc = wr_data[6];
                    d.cfg.irq_en  = wr_data[7];
                    d.cfg.hw_mode = wr_data[8];
                    d.cfg.sel     = wr_data[9 +: SEL_W];
                    if (wr_data[16]) d.done = 1'b0;
                end
            endcase
        end
        if (adv) begin
            if (q.cfg.src_inc) d.src = q.src + step;
            if (q.cfg.dst_inc) d.dst = q.dst + step;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.done     = 1'b1;
                d.cfg.en   = 1'b0;
                d.cfg.pend = 1'b0;
            end
        end
        if (svc) d.cfg.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (rd_field)
            2'd0:    rd_data = 32'(q.src);
            2'd1:    rd_data = 32'(q.dst);
            2'd2:    rd_data = 32'(q.cnt);
            default: rd_data = pack_ctrl(q.cfg, q.done);
        endcase
    end

    assign req_o     = q.cfg.en & (q.cfg.hw_mode ? hw_req[q.cfg.sel] : q.cfg.pend);
    assign last_o    = (q.cnt == CNT_W'(1));
    assign src_o     = q.src;
    assign dst_o     = q.dst;
    assign burst_o   = q.cfg.burst;
    assign size_o    = q.cfg.size;
    assign hw_mode_o = q.cfg.hw_mode;
    assign sel_o     = q.cfg.sel;
    assign irq_o     = q.done & q.cfg.irq_en;

    // R10: the final element leaves the channel done and disabled
    a_r10_end_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && q.cnt == CNT_W'(1) && !wr_en) |=> (q.done && !q.cfg.en));

    // R9: a count of zero does not finish on its first element
    a_r9_zero_not_last: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && q.cnt == '0 && !wr_en) |=> (!q.done && q.cnt == {CNT_W{1'b1}}));
endmodule

// File: rtl/dmac_arb.sv
module dmac_arb
    import dmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  req,
    input  logic            rr_mode,
    input  logic            take,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_idx
);
    logic [CH_W-1:0] last_q, last_d;

    always_comb begin
        gnt_valid = |req;
        if (req[0] && req[1])
            gnt_idx = rr_mode ? ~last_q : '0;
        else
            gnt_idx = req[1] ? CH_W'(1) : '0;
        last_d = take ? gnt_idx : last_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= CH_W'(1);
        else        last_q <= last_d;
    end

    // R11: in fixed mode a request from channel 0 always wins
    a_r11_fixed_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rr_mode && req[0]) |=> (last_q == '0));

    // R12: in rotating mode with both requesting, the grant moves away from the last one
    a_r12_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (take && rr_mode && (&req)) |=> (last_q != $past(last_q)));
endmodule

// File: rtl/dmac_eng.sv
module dmac_eng
    import dmac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     gnt_valid,
    input  logic [CH_W-1:0]          gnt_idx,
    output logic                     take,
    input  logic [NCH-1:0][AW-1:0]   src,
    input  logic [NCH-1:0][AW-1:0]   dst,
    input  logic [NCH-1:0][1:0]      size,
    input  logic [NCH-1:0]           burst,
    input  logic [NCH-1:0]           last,
    output logic [NCH-1:0]           adv,
    output logic [NCH-1:0]           svc,
    output logic                     bus_req,
    output logic                     bus_we,
    output logic [AW-1:0]            bus_addr,
    output logic [1:0]               bus_size,
    output logic [DW-1:0]            bus_wdata,
    input  logic [DW-1:0]            bus_rdata,
    input  logic                     bus_ready
);
    typedef struct packed {
        eng_st_e         st;
        logic [CH_W-1:0] ch;
        logic [DW-1:0]   data;
    } eng_s;

    eng_s q, d;

    always_comb begin
        d   = q;
        adv = '0;
        svc = '0;
        take      = (q.st == ST_IDLE) && gnt_valid;
        bus_req   = (q.st != ST_IDLE);
        bus_we    = (q.st == ST_WR);
        bus_addr  = (q.st == ST_WR) ? dst[q.ch] : src[q.ch];
        bus_size  = size[q.ch];
        bus_wdata = q.data;
        case (q.st)
            ST_IDLE: begin
                if (gnt_valid) begin
                    d.ch = gnt_idx;
                    d.st = ST_RD;
                end
            end
            ST_RD: begin
                if (bus_ready) begin
                    d.data = bus_rdata & size_mask(size[q.ch]);
                    d.st   = ST_WR;
                end
            end
            default: begin
                if (bus_ready) begin
                    adv[q.ch] = 1'b1;
                    if (!burst[q.ch] || last[q.ch]) begin
                        svc[q.ch] = 1'b1;
                        d.st      = ST_IDLE;
                    end else begin
                        d.st = ST_RD;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, ch: '0, data: '0};
        else        q <= d;
    end

    // R13: a stalled access is held unchanged
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_we) && $stable(bus_addr)));

    // R4: cycle-steal hands the bus back after each element
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ready && !burst[q.ch]) |=> !bus_req);

    // R5: burst chains straight into the next read
    a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_ready && burst[q.ch] && !last[q.ch]) |=> (bus_req && !bus_we));
endmodule

// File: rtl/dual_dma.sv
module dual_dma
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NSRC-1:0]   hw_req,
    output logic [NSRC-1:0]   hw_ack,
    output logic              bus_req,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     bus_rdata,
    input  logic              bus_ready,
    output logic              irq
);
    logic rr_q, rr_d;

    logic [NCH-1:0][31:0]      ch_rd;
    logic [NCH-1:0]            ch_req, ch_last, ch_burst, ch_hw, ch_irq, ch_adv, ch_svc;
    logic [NCH-1:0][AW-1:0]    ch_src, ch_dst;
    logic [NCH-1:0][1:0]       ch_size;
    logic [NCH-1:0][SEL_W-1:0] ch_sel;
    logic                      gnt_valid, take;
    logic [CH_W-1:0]           gnt_idx;
    logic                      glob_sel;

    assign glob_sel = reg_addr[REG_AW-1];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dmac_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (reg_we && !glob_sel && (reg_addr[2] == c[0])),
            .wr_field  (reg_addr[1:0]),
            .wr_data   (reg_wdata),
            .rd_field  (reg_addr[1:0]),
            .rd_data   (ch_rd[c]),
            .hw_req    (hw_req),
            .adv       (ch_adv[c]),
            .svc       (ch_svc[c]),
            .req_o     (ch_req[c]),
            .last_o    (ch_last[c]),
            .src_o     (ch_src[c]),
            .dst_o     (ch_dst[c]),
            .burst_o   (ch_burst[c]),
            .size_o    (ch_size[c]),
            .hw_mode_o (ch_hw[c]),
            .sel_o     (ch_sel[c]),
            .irq_o     (ch_irq[c])
        );
    end

    dmac_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .rr_mode   (rr_q),
        .take      (take),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    dmac_eng u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .take      (take),
        .src       (ch_src),
        .dst       (ch_dst),
        .size      (ch_size),
        .burst     (ch_burst),
        .last      (ch_last),
        .adv       (ch_adv),
        .svc       (ch_svc),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready)
    );

    always_comb begin
        rr_d = rr_q;
        if (reg_we && glob_sel && reg_addr[2:0] == 3'd0) rr_d = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= 1'b0;
        else        rr_q <= rr_d;
    end

    always_comb begin
        if (glob_sel)
            reg_rdata = (reg_addr[2:0] == 3'd0) ? {31'b0, rr_q} : 32'b0;
        else
            reg_rdata = ch_rd[reg_addr[2]];
    end

    always_comb begin
        hw_ack = '0;
        for (int c = 0; c < NCH; c++)
            if (ch_svc[c] && ch_hw[c]) hw_ack[ch_sel[c]] = 1'b1;
    end

    assign irq = |ch_irq;

    // R6: at most one acknowledge line is active in any cycle
    a_r6_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hw_ack));

    // R6: an acknowledge only comes with an accepted write
    a_r6_ack_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_ack) |-> (bus_req && bus_we && bus_ready));
endmodule

// File: tb/dual_dma_tb_top.sv
`timescale 1ns/1ps
module dual_dma_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hw_req = '0;
    logic [3:0]  hw_ack;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic [1:0]  bus_size;
    logic        bus_ready = 1'b1;
    logic        irq;

    int checks = 0;
    int failures = 0;
    logic [7:0] mem [0:1023];
    logic [7:0] shadow [0:1023];
    int rel_cnt = 0;
    int ack_cnt [4];
    int hold_viol = 0;
    logic rand_ready = 1'b0;
    logic logging = 1'b0;
    int log_n = 0;
    logic log_ch [8];
    logic prev_req = 1'b0;
    logic hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;

    always #2.5 clk = ~clk;

    dual_dma dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_req(hw_req),
        .hw_ack(hw_ack), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq(irq)
    );

    assign bus_rdata = {mem[10'(bus_addr[9:0] + 10'd3)], mem[10'(bus_addr[9:0] + 10'd2)],
                        mem[10'(bus_addr[9:0] + 10'd1)], mem[bus_addr[9:0]]};

    // Bus slave, monitors
    always @(negedge clk) begin
        bus_ready = rand_ready ? (($urandom % 4) != 0) : 1'b1;
        #1;
        if (rst_n) begin
            if (hold_pend && !(bus_req && bus_addr == hold_addr)) hold_viol++;
            hold_pend = bus_req && !bus_ready;
            hold_addr = bus_addr;
            if (prev_req && !bus_req) rel_cnt++;
            prev_req = bus_req;
            for (int i = 0; i < 4; i++) if (hw_ack[i]) ack_cnt[i]++;
            if (bus_req && !bus_we && bus_ready && logging && log_n < 8) begin
                log_ch[log_n] = bus_addr[9];
                log_n++;
            end
            if (bus_req && bus_we && bus_ready) begin
                for (int b = 0; b < (bus_size == 2'd0 ? 1 : bus_size == 2'd1 ? 2 : 4); b++)
                    mem[10'(bus_addr[9:0] + 10'(b))] = bus_wdata[8*b +: 8];
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic en, input logic rq, input logic bst,
            input logic [1:0] sz, input logic si, input logic di, input logic ie,
            input logic hw, input logic [1:0] sel);
        mk_ctrl = {15'b0, 1'b0, 5'b0, sel, hw, ie, di, si, sz, bst, rq, en};
    endfunction

    function automatic int stepof(input logic [1:0] sz);
        stepof = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    task automatic model(input int s, input int d, input int n, input logic [1:0] sz,
                         input logic si, input logic di);
        for (int k = 0; k < n; k++) begin
            for (int b = 0; b < stepof(sz); b++)
                shadow[(d + b) & 1023] = shadow[(s + b) & 1023];
            if (si) s += stepof(sz);
            if (di) d += stepof(sz);
        end
    endtask

    task automatic cmp_mem(input string tag);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 1024; i++)
            if (mem[i] !== shadow[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        chk(bad == 0, tag, 32'(bad), 32'd0);
        if (bad != 0) $display("  first mismatch at byte %0d", first);
    endtask

    task automatic setup(input int c, input int s, input int d, input int n);
        wr(4'(c*4+0), 32'(s));
        wr(4'(c*4+1), 32'(d));
        wr(4'(c*4+2), 32'(n));
    endtask

    task automatic wait_done(input int c, output logic ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int t = 0; t < 5000; t++) begin
            rd(4'(c*4+3), v);
            if (v[16]) begin ok = 1'b1; break; end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_served(input int c);
        logic [31:0] v;
        for (int t = 0; t < 2000; t++) begin
            rd(4'(c*4+3), v);
            if (!v[1]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic hw_pulse(input int line);
        @(negedge clk);
        hw_req[line] = 1'b1;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            #2;
            if (hw_ack[line]) break;
        end
        hw_req[line] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic clr_counts();
        rel_cnt = 0;
        for (int i = 0; i < 4; i++) ack_cnt[i] = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic ok;
        int seed_val;
        seed_val = $urandom(32'd20240611);
        for (int i = 0; i < 1024; i++) begin
            mem[i] = 8'($urandom);
            shadow[i] = mem[i];
        end
        for (int i = 0; i < 4; i++) ack_cnt[i] = 0;
        repeat (4) @(negedge clk);

        // R1: reset values
        chk(!bus_req && !irq && hw_ack == 4'b0, "R1 outputs at reset", {30'b0, bus_req, irq}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(4'd3, v); chk(v == 32'd0, "R1 ctrl0 reset", v, 32'd0);
        rd(4'd6, v); chk(v == 32'd0, "R1 cnt1 reset", v, 32'd0);
        rd(4'd8, v); chk(v == 32'd0, "R1 mode reset", v, 32'd0);

        // R2: readback
        setup(1, 32'h1234_5678, 32'h0BAD_F00D, 32'h0000_BEEF);
        rd(4'd4, v); chk(v == 32'h1234_5678, "R2 src1 readback", v, 32'h1234_5678);
        rd(4'd5, v); chk(v == 32'h0BAD_F00D, "R2 dst1 readback", v, 32'h0BAD_F00D);
        rd(4'd6, v); chk(v == 32'h0000_BEEF, "R2 cnt1 readback", v, 32'h0000_BEEF);
        wr(4'd7, mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3));
        rd(4'd7, v);
        chk(v == mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3), "R3 ctrl fields readback", v,
            mk_ctrl(1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'd3));
        wr(4'd7, 32'd0);

        // R5, R10: software burst, 32-bit, incrementing
        clr_counts();
        setup(0, 32'h040, 32'h140, 4);
        wr(4'd3, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0));
        model(32'h040, 32'h140, 4, 2'd2, 1'b1, 1'b1);
        wait_done(0, ok);
        chk(ok, "R10 burst done flag", {31'b0, ok}, 32'd1);
        chk(rel_cnt == 1, "R5 burst bus releases", 32'(rel_cnt), 32'd1);
        cmp_mem("R5 burst memory");
        rd(4'd3, v); chk(v[0] == 1'b0, "R10 enable cleared", {31'b0, v[0]}, 32'd0);
        chk(irq == 1'b1, "R10 irq raised", {31'b0, irq}, 32'd1);
        wr(4'd3, 32'h0001_0000);
        @(negedge clk);
        chk(irq == 1'b0, "R10 done cleared by write-one", {31'b0, irq}, 32'd0);

        // R4: cycle-steal, 16-bit, one element per software request
        clr_counts();
        setup(1, 32'h260, 32'h360, 3);
        wr(4'd7, mk_ctrl(1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
        wait_served(1);
        model(32'h260, 32'h360, 1, 2'd1, 1'b1, 1'b1);
        rd(4'd6, v); chk(v == 32'd2, "R4 count after one request", v, 32'd2);
        chk(rel_cnt == 1, "R4 one release per request", 32'(rel_cnt), 32'd1);
        rd(4'd4, v); chk(v == 32'h262, "R8 16-bit source step", v, 32'h262);
        for (int k = 0; k < 2; k++) begin
            wr(4'd7, mk_ctrl(1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
            wait_served(1);
        end
        model(32'h262, 32'h362, 2, 2'd1, 1'b1, 1'b1);
        rd(4'd7, v); chk(v[16] == 1'b1, "R4 done after third request", {31'b0, v[16]}, 32'd1);
        chk(rel_cnt == 3, "R4 three releases", 32'(rel_cnt), 32'd3);
        cmp_mem("R7 16-bit cycle-steal memory");
        wr(4'd7, 32'h0001_0000);

        // R8: fixed source, 8-bit
        setup(0, 32'h0A0, 32'h1A0, 5);
        wr(4'd3, mk_ctrl(1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0));
        model(32'h0A0, 32'h1A0, 5, 2'd0, 1'b0, 1'b1);
        wait_done(0, ok);
        cmp_mem("R8 fixed source memory");
        rd(4'd0, v); chk(v == 32'h0A0, "R8 fixed source unchanged", v, 32'h0A0);
        rd(4'd1, v); chk(v == 32'h1A5, "R8 8-bit destination step", v, 32'h1A5);
        wr(4'd3, 32'h0001_0000);

        // R9: count zero means 65536
        rand_ready = 1'b1;
        setup(0, 32'h0C0, 32'h1C0, 0);
        for (int k = 0; k < 3; k++) begin
            wr(4'd3, mk_ctrl(1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0));
            wait_served(0);
        end
        model(32'h0C0, 32'h1C0, 3, 2'd0, 1'b1, 1'b1);
        rd(4'd2, v); chk(v == 32'h0000_FFFD, "R9 count wraps from zero", v, 32'h0000_FFFD);
        rd(4'd3, v); chk(v[16] == 1'b0, "R9 not done", {31'b0, v[16]}, 32'd0);
        cmp_mem("R9 zero-count memory");
        wr(4'd3, 32'd0);

        // R6: hardware cycle-steal on line 2, channel 1
        clr_counts();
        setup(1, 32'h240, 32'h340, 2);
        wr(4'd7, mk_ctrl(1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2));
        hw_pulse(2);
        hw_pulse(2);
        model(32'h240, 32'h340, 2, 2'd1, 1'b1, 1'b1);
        chk(ack_cnt[2] == 2, "R6 ack on selected line", 32'(ack_cnt[2]), 32'd2);
        chk(ack_cnt[0] + ack_cnt[1] + ack_cnt[3] == 0, "R6 no ack elsewhere",
            32'(ack_cnt[0] + ack_cnt[1] + ack_cnt[3]), 32'd0);
        rd(4'd7, v); chk(v[16] == 1'b1, "R6 hw channel done", {31'b0, v[16]}, 32'd1);
        cmp_mem("R6 hw cycle-steal memory");
        wr(4'd7, 32'h0001_0000);

        // R6, R5: hardware burst on line 1, one acknowledge
        clr_counts();
        setup(0, 32'h080, 32'h180, 3);
        wr(4'd3, mk_ctrl(1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 2'd1));
        hw_pulse(1);
        model(32'h080, 32'h180, 3, 2'd2, 1'b1, 1'b1);
        wait_done(0, ok);
        chk(ack_cnt[1] == 1, "R6 single ack for burst", 32'(ack_cnt[1]), 32'd1);
        chk(rel_cnt == 1, "R5 hw burst releases", 32'(rel_cnt), 32'd1);
        cmp_mem("R5 hw burst memory");
        wr(4'd3, 32'h0001_0000);

        // R11: fixed priority
        for (int mode = 0; mode < 2; mode++) begin
            wr(4'd8, 32'(mode));
            setup(0, 32'h010 + mode*16, 32'h110 + mode*16, 2);
            setup(1, 32'h210 + mode*16, 32'h310 + mode*16, 2);
            wr(4'd3, mk_ctrl(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0));
            wr(4'd7, mk_ctrl(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3));
            model(32'h010 + mode*16, 32'h110 + mode*16, 2, 2'd0, 1'b1, 1'b1);
            model(32'h210 + mode*16, 32'h310 + mode*16, 2, 2'd0, 1'b1, 1'b1);
            log_n = 0;
            logging = 1'b1;
            @(negedge clk);
            hw_req[0] = 1'b1; hw_req[3] = 1'b1;
            wait_done(1, ok);
            wait_done(0, ok);
            hw_req = '0;
            logging = 1'b0;
            if (mode == 0) begin
                chk(log_n == 4 && {log_ch[0], log_ch[1], log_ch[2], log_ch[3]} == 4'b0011,
                    "R11 fixed order", {28'b0, log_ch[0], log_ch[1], log_ch[2], log_ch[3]}, 32'b0011);
            end else begin
                chk(log_n == 4 && log_ch[0] != log_ch[1] && log_ch[1] != log_ch[2] && log_ch[2] != log_ch[3],
                    "R12 rotating order", {28'b0, log_ch[0], log_ch[1], log_ch[2], log_ch[3]}, 32'b0101);
            end
            cmp_mem(mode == 0 ? "R11 priority memory" : "R12 rotating memory");
            wr(4'd3, 32'h0001_0000);
            wr(4'd7, 32'h0001_0000);
        end

        // R7, R8, R3: random software transfers with random bus stalls
        for (int it = 0; it < 24; it++) begin
            int c, s, d, n;
            logic [1:0] sz;
            logic si, di, bst;
            c   = $urandom % 2;
            sz  = 2'($urandom % 3);
            si  = 1'($urandom);
            di  = 1'($urandom);
            bst = 1'($urandom);
            n   = 1 + ($urandom % 10);
            s   = (c ? 32'h200 : 32'h000) + ($urandom % 48) * 4;
            d   = (c ? 32'h300 : 32'h100) + ($urandom % 48) * 4;
            setup(c, s, d, n);
            model(s, d, n, sz, si, di);
            if (bst) begin
                wr(4'(c*4+3), mk_ctrl(1'b1, 1'b1, 1'b1, sz, si, di, 1'b0, 1'b0, 2'd0));
            end else begin
                for (int k = 0; k < n; k++) begin
                    wr(4'(c*4+3), mk_ctrl(1'b1, 1'b1, 1'b0, sz, si, di, 1'b0, 1'b0, 2'd0));
                    wait_served(c);
                end
            end
            wait_done(c, ok);
            rd(4'(c*4+0), v);
            chk(v == 32'(s + (si ? n*stepof(sz) : 0)), "R8 random source pointer", v,
                32'(s + (si ? n*stepof(sz) : 0)));
            wr(4'(c*4+3), 32'h0001_0000);
        end
        cmp_mem("R7 random transfers memory");
        chk(hold_viol == 0, "R13 stalled access held", 32'(hold_viol), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule